// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block sits on an 8051-style external bus and turns each CPU cycle into a single device select. The devices are a main flash of eight 32 KB sectors, a boot flash of four smaller sectors, one SRAM, and a 256-byte window of control registers. The bus is a 16-bit address, three active-low strobes and a byte data path. The program-fetch strobe `psen_n` marks code space. The read strobe `rd_n` and the write strobe `wr_n` mark data space.

The control window contains an 8-bit page register. The page is joined above the 16-bit CPU address to form a wider flash address. As a result, the same CPU address reaches different main-flash sectors depending on the page. Parameters set the base address of each region, its size, and whether it lives in code or data space. The SRAM and the control window are always in data space. The selects are active-high and combinational on the bus inputs. The page register is the only state in the block.

Top module: `paged_cs_decoder`

## Requirements
- R1: When `psen_n`, `rd_n` and `wr_n` are all high, every select output (`main_sect`, `boot_sect`, `sram_cs`, `regs_cs`) is low.
- R2: In code space (with the default placement) a main-flash access asserts exactly one bit of `main_sect`. Its index is bits 17..15 of `{page, addr}`, so index = `{page[1:0], addr[15]}` for 8 sectors of 32 KB.
- R3: When the page value is 4 or more (beyond the 256 KB main flash), no `main_sect` bit is asserted.
- R4: The boot flash covers 0xC000–0xFFFF and selects sector `addr[13:12]` on `boot_sect`. With `BOOT_IN_CODE=1` only `psen_n` qualifies it; with `BOOT_IN_CODE=0` only `rd_n`/`wr_n` qualify it.
- R5: `sram_cs` is asserted for `rd_n` or `wr_n` cycles in 0x6000–0x7FFF (outside the control window) and never for a `psen_n`-only cycle.
- R6: `regs_cs` is asserted for `rd_n`/`wr_n` cycles in 0x7F00–0x7FFF and never for a `psen_n`-only cycle.
- R7: Where regions overlap, the order of precedence is control window, SRAM, boot flash, main flash. At most one device is selected at any time.
- R8: A write cycle at window offset 0xE0 loads `wdata` into the page register on the first clock after `wr_n` rises. A read of offset 0xE0 returns the page value on `rdata`, and the next decode uses the new page.
- R9: Reads of any other window offset return 0x00. Writes to those offsets leave the page register unchanged.
- R10: Reset sets the page register to 0x00.
- R11: `rdata_oe` is high only while `regs_cs` is high and `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the write strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | CPU address |
| psen_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| wdata | input | 8 | Write data for the control window |
| rdata | output | 8 | Read data from the control window |
| rdata_oe | output | 1 | High while `rdata` should drive the bus |
| main_sect | output | 8 | One-hot main-flash sector selects |
| boot_sect | output | 4 | One-hot boot-flash sector selects |
| sram_cs | output | 1 | SRAM select |
| regs_cs | output | 1 | Control window select |

## Verification
The bench builds two copies side by side on the same bus. One copy uses the defaults, with the boot flash in code space where it overlaps the upper half of the main flash. The other copy has `BOOT_IN_CODE=0`. The first copy reaches boot-over-main precedence under `psen_n`. The second shows the same addresses falling through to main flash in code space and reaching the boot flash only on data strobes. The default SRAM range contains the control window, so window-over-SRAM precedence is exercised. Page values 0, 2, 3, 4 and 0xFF cover every page bit that forms the sector index and the out-of-range gate.

// File: rtl/paged_cs_pkg.sv
`timescale 1ns/1ps
package paged_cs_pkg;
  localparam int CPU_AW = 16;

  typedef logic [CPU_AW-1:0] cpu_addr_t;

  // Kind of bus cycle in progress: code fetch and/or data access.
  typedef struct packed {
    logic code;
    logic data;
  } cyc_kind_t;

  // True when address a lies in the aligned 2**aw window containing base.
  function automatic logic win_hit(input cpu_addr_t a, input cpu_addr_t base,
                                   input int unsigned aw);
    cpu_addr_t mask;
    if (aw >= CPU_AW) mask = '0;
    else mask = ~((cpu_addr_t'(1) << aw) - cpu_addr_t'(1));
    return (a & mask) == (base & mask);
  endfunction

  // A region placed in code space answers to fetches, otherwise to data cycles.
  function automatic logic space_ok(input cyc_kind_t k, input bit in_code);
    return in_code ? k.code : k.data;
  endfunction

  // Sector number within the paged address {page, a}.
  function automatic int unsigned ext_index(input logic [7:0] page, input cpu_addr_t a,
                                            input int unsigned sect_aw);
    logic [CPU_AW+7:0] xa;
    xa = {page, a};
    return int'(xa >> sect_aw);
  endfunction
endpackage

// File: rtl/paged_cs_window.sv
`timescale 1ns/1ps
module paged_cs_window
  import paged_cs_pkg::*;
#(
  parameter logic [15:0] BASE    = 16'h0000,
  parameter int unsigned AW      = 16,
  parameter bit          IN_CODE = 1'b1
) (
  input  cpu_addr_t addr,
  input  cyc_kind_t kind,
  output logic      hit
);
  logic range_ok;
  logic kind_ok;

  assign range_ok = win_hit(addr, BASE, AW);
  assign kind_ok  = space_ok(kind, IN_CODE);
  assign hit      = range_ok && kind_ok;
endmodule

// File: rtl/paged_cs_arbiter.sv
`timescale 1ns/1ps
module paged_cs_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // Index 0 has the highest priority: scan from the lowest-priority end
  // so that the last request found wins.
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = ONE << i;
    end
  end
endmodule

// File: rtl/paged_cs_onehot.sv
`timescale 1ns/1ps
module paged_cs_onehot #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  sel
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel[g] = en && (idx == IW'(g));
  end
endmodule

// File: rtl/paged_cs_page_reg.sv
`timescale 1ns/1ps
module paged_cs_page_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] page,
  output logic         commit
);
  logic         wr_q;
  logic         hold_hit;
  logic [W-1:0] hold_data;

  // The strobe has just risen, and the last low sample addressed the page slot.
  assign commit = wr_n && !wr_q && hold_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      hold_hit  <= 1'b0;
      hold_data <= '0;
      page      <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n) begin
        hold_hit  <= wr_hit;
        hold_data <= wdata;
      end
      if (commit) page <= hold_data;
    end
  end
endmodule

// File: rtl/paged_cs_decoder.sv
`timescale 1ns/1ps
module paged_cs_decoder
  import paged_cs_pkg::*;
#(
  parameter int          MAIN_SECTORS = 8,
  parameter int          MAIN_SECT_AW = 15,
  parameter bit          MAIN_IN_CODE = 1'b1,
  parameter logic [15:0] BOOT_BASE    = 16'hC000,
  parameter int          BOOT_SECTORS = 4,
  parameter int          BOOT_SECT_AW = 12,
  parameter bit          BOOT_IN_CODE = 1'b1,
  parameter logic [15:0] SRAM_BASE    = 16'h6000,
  parameter int          SRAM_AW      = 13,
  parameter logic [15:0] REGS_BASE    = 16'h7F00,
  parameter logic [7:0]  PAGE_OFS     = 8'hE0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             addr,
  input  logic                    psen_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    rdata_oe,
  output logic [MAIN_SECTORS-1:0] main_sect,
  output logic [BOOT_SECTORS-1:0] boot_sect,
  output logic                    sram_cs,
  output logic                    regs_cs
);
  localparam int PAGE_W      = 8;
  localparam int REGS_AW     = 8;
  localparam int MAIN_IDX_W  = (MAIN_SECTORS > 1) ? $clog2(MAIN_SECTORS) : 1;
  localparam int BOOT_IDX_W  = (BOOT_SECTORS > 1) ? $clog2(BOOT_SECTORS) : 1;
  localparam int BOOT_AW     = BOOT_SECT_AW + BOOT_IDX_W;
  localparam int MAIN_PG_BITS = (MAIN_IDX_W + MAIN_SECT_AW > CPU_AW)
                                ? (MAIN_IDX_W + MAIN_SECT_AW - CPU_AW) : 0;
  localparam int MAIN_PAGES  = 1 << MAIN_PG_BITS;
  localparam int N_DEV       = 4;
  localparam int G_REGS = 0;
  localparam int G_SRAM = 1;
  localparam int G_BOOT = 2;
  localparam int G_MAIN = 3;

  cyc_kind_t           kind;
  logic                regs_hit, sram_hit, boot_hit, main_win_hit;
  logic                main_page_ok, main_hit;
  logic [N_DEV-1:0]    dev_req, dev_gnt;
  logic [PAGE_W-1:0]   page_q;
  logic                page_commit;
  logic                page_slot, page_wr_hit, regs_rd;
  logic [MAIN_IDX_W-1:0] main_idx;
  logic [BOOT_IDX_W-1:0] boot_idx;

  assign kind.code = !psen_n;
  assign kind.data = !rd_n || !wr_n;

  paged_cs_window #(.BASE(REGS_BASE), .AW(REGS_AW), .IN_CODE(1'b0)) u_regs_win (
    .addr(addr), .kind(kind), .hit(regs_hit));
  paged_cs_window #(.BASE(SRAM_BASE), .AW(SRAM_AW), .IN_CODE(1'b0)) u_sram_win (
    .addr(addr), .kind(kind), .hit(sram_hit));
  paged_cs_window #(.BASE(BOOT_BASE), .AW(BOOT_AW), .IN_CODE(BOOT_IN_CODE)) u_boot_win (
    .addr(addr), .kind(kind), .hit(boot_hit));
  paged_cs_window #(.BASE(16'h0000), .AW(CPU_AW), .IN_CODE(MAIN_IN_CODE)) u_main_win (
    .addr(addr), .kind(kind), .hit(main_win_hit));

  // Pages beyond the end of the main flash select nothing.
  assign main_page_ok = int'(page_q) < MAIN_PAGES;
  assign main_hit     = main_win_hit && main_page_ok;

  assign dev_req[G_REGS] = regs_hit;
  assign dev_req[G_SRAM] = sram_hit;
  assign dev_req[G_BOOT] = boot_hit;
  assign dev_req[G_MAIN] = main_hit;

  paged_cs_arbiter #(.N(N_DEV)) u_arb (.req(dev_req), .gnt(dev_gnt));

  assign main_idx = MAIN_IDX_W'(ext_index(page_q, addr, MAIN_SECT_AW));
  assign boot_idx = BOOT_IDX_W'(ext_index(8'h00, addr, BOOT_SECT_AW));

  paged_cs_onehot #(.N(MAIN_SECTORS), .IW(MAIN_IDX_W)) u_main_dec (
    .en(dev_gnt[G_MAIN]), .idx(main_idx), .sel(main_sect));
  paged_cs_onehot #(.N(BOOT_SECTORS), .IW(BOOT_IDX_W)) u_boot_dec (
    .en(dev_gnt[G_BOOT]), .idx(boot_idx), .sel(boot_sect));

  assign sram_cs = dev_gnt[G_SRAM];
  assign regs_cs = dev_gnt[G_REGS];

  assign page_slot   = addr[REGS_AW-1:0] == PAGE_OFS;
  assign page_wr_hit = regs_cs && !wr_n && page_slot;
  assign regs_rd     = regs_cs && !rd_n;

  paged_cs_page_reg #(.W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_hit(page_wr_hit),
    .wdata(wdata), .page(page_q), .commit(page_commit));

  assign rdata_oe = regs_rd;
  assign rdata    = (regs_rd && page_slot) ? page_q : 8'h00;
endmodule

// File: rtl/paged_cs_decoder_chk.sv
`timescale 1ns/1ps
module paged_cs_decoder_chk #(
  parameter int         MAIN_N     = 8,
  parameter int         BOOT_N     = 4,
  parameter int         MAIN_PAGES = 4,
  parameter logic [7:0] PAGE_OFS   = 8'hE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       addr,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [7:0]        rdata,
  input logic              rdata_oe,
  input logic [MAIN_N-1:0] main_sect,
  input logic [BOOT_N-1:0] boot_sect,
  input logic              sram_cs,
  input logic              regs_cs,
  input logic [7:0]        page_q,
  input logic              page_commit
);
  logic idle_bus, code_only;
  assign idle_bus  = psen_n && rd_n && wr_n;
  assign code_only = !psen_n && rd_n && wr_n;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bus |-> (main_sect == '0 && boot_sect == '0 && !sram_cs && !regs_cs)); // R1
  AST_MAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(main_sect) && $onehot0(boot_sect)); // R2
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sect != '0) |-> (int'(page_q) < MAIN_PAGES)); // R3
  AST_SRAM_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    code_only |-> !sram_cs); // R5
  AST_REGS_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    code_only |-> !regs_cs); // R6
  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|main_sect, |boot_sect, sram_cs, regs_cs}) <= 1); // R7
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !page_commit |=> $stable(page_q)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && addr[7:0] != PAGE_OFS) |-> (rdata == 8'h00)); // R9
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (regs_cs && !rd_n)); // R11
endmodule

bind paged_cs_decoder paged_cs_decoder_chk #(
  .MAIN_N(MAIN_SECTORS), .BOOT_N(BOOT_SECTORS),
  .MAIN_PAGES(MAIN_PAGES), .PAGE_OFS(PAGE_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .rdata(rdata), .rdata_oe(rdata_oe), .main_sect(main_sect), .boot_sect(boot_sect),
  .sram_cs(sram_cs), .regs_cs(regs_cs), .page_q(page_q), .page_commit(page_commit)
);

// File: tb/paged_cs_decoder_tb.sv
`timescale 1ns/1ps
module paged_cs_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] wdata = 8'h00;

  logic [7:0] rdata_a, rdata_b;
  logic oe_a, oe_b;
  logic [7:0] main_a, main_b;
  logic [3:0] boot_a, boot_b;
  logic sram_a, sram_b, regs_a, regs_b;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  paged_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata_a), .rdata_oe(oe_a), .main_sect(main_a),
    .boot_sect(boot_a), .sram_cs(sram_a), .regs_cs(regs_a));

  paged_cs_decoder #(.BOOT_IN_CODE(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata_b), .rdata_oe(oe_b), .main_sect(main_b),
    .boot_sect(boot_b), .sram_cs(sram_b), .regs_cs(regs_b));

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected main select from the paged sector rule (8 x 32K, 4 pages).
  function automatic int exp_main(input int page, input int a);
    int s;
    if (page >= 4) return 0;
    s = ((page << 16) | a) >> 15;
    return 1 << s;
  endfunction

  task automatic cycle(input logic [15:0] a, input bit p, input bit r, input bit w,
                       input logic [7:0] d);
    @(negedge clk);
    addr = a; psen_n = !p; rd_n = !r; wr_n = !w; wdata = d;
    #1;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  task automatic write_reg(input logic [7:0] ofs, input logic [7:0] d);
    cycle({8'h7F, ofs}, 0, 0, 1, d);
    @(posedge clk); @(posedge clk);
    bus_idle();            // wr_n rises here, commit on the next edge
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1", "main after reset", main_a, 0);
    check("R1", "boot after reset", boot_a, 0);
    cycle(16'h7FE0, 0, 1, 0, 8'h00);
    check("R10", "page after reset", rdata_a, 8'h00);
    check("R11", "oe during page read", oe_a, 1);
    bus_idle();
  endtask

  task automatic t_idle();
    foreach (addr_list[k]) begin
      cycle(addr_list[k], 0, 0, 0, 8'hA5);
      check("R1", "idle selects dut_i", {main_a, boot_a, sram_a, regs_a}, 0);
      check("R1", "idle selects dut_b", {main_b, boot_b, sram_b, regs_b}, 0);
    end
  endtask
  logic [15:0] addr_list [4] = '{16'h0000, 16'h6100, 16'h7FE0, 16'hC000};

  task automatic t_main_page0();
    cycle(16'h0123, 1, 0, 0, 8'h00);
    check("R2", "psen 0x0123 page0", main_a, exp_main(0, 16'h0123));
    cycle(16'h8000, 1, 0, 0, 8'h00);
    check("R2", "psen 0x8000 page0", main_a, exp_main(0, 16'h8000));
    cycle(16'hC000, 1, 0, 0, 8'h00);
    check("R7", "boot beats main dut_i", {main_a, boot_a}, {8'h00, 4'b0001});
    check("R4", "boot data-only falls to main", {main_b, boot_b}, {8'h02, 4'b0000});
    bus_idle();
  endtask

  task automatic t_paging();
    write_reg(8'hE0, 8'h02);
    cycle(16'h7FE0, 0, 1, 0, 8'h00);
    check("R8", "page readback", rdata_a, 8'h02);
    cycle(16'h1000, 1, 0, 0, 8'h00);
    check("R8", "page2 low half", main_a, exp_main(2, 16'h1000));
    cycle(16'h9000, 1, 0, 0, 8'h00);
    check("R2", "page2 high half", main_a, exp_main(2, 16'h9000));
    bus_idle();
    write_reg(8'hE0, 8'h03);
    cycle(16'h8000, 1, 0, 0, 8'h00);
    check("R2", "page3 top sector", main_a, 8'h80);
    bus_idle();
    write_reg(8'hE0, 8'h04);
    cycle(16'h0000, 1, 0, 0, 8'h00);
    check("R3", "page4 no main", main_a, 0);
    bus_idle();
    write_reg(8'hE0, 8'hFF);
    cycle(16'h8000, 1, 0, 0, 8'h00);
    check("R3", "page 0xFF no main", main_a, 0);
    cycle(16'hD000, 1, 0, 0, 8'h00);
    check("R4", "boot unpaged at 0xFF", boot_a, 4'b0010);
    bus_idle();
    write_reg(8'hE0, 8'h00);
  endtask

  task automatic t_boot();
    cycle(16'hF000, 1, 0, 0, 8'h00);
    check("R4", "boot sector3 psen", boot_a, 4'b1000);
    cycle(16'hE000, 0, 1, 0, 8'h00);
    check("R4", "dut_i ignores rd at boot", {main_a, boot_a}, 0);
    check("R4", "dut_b boot sector2 on rd", boot_b, 4'b0100);
    cycle(16'hC800, 0, 0, 1, 8'h00);
    check("R4", "dut_b boot sector0 on wr", boot_b, 4'b0001);
    cycle(16'hE000, 1, 0, 0, 8'h00);
    check("R4", "dut_b psen goes to main", {main_b, boot_b}, {8'h02, 4'b0000});
    bus_idle();
  endtask

  task automatic t_sram_regs();
    cycle(16'h6000, 0, 1, 0, 8'h00);
    check("R5", "sram rd 0x6000", {sram_a, regs_a}, 2'b10);
    check("R11", "no oe on sram read", oe_a, 0);
    cycle(16'h7EFF, 0, 0, 1, 8'h00);
    check("R5", "sram wr 0x7EFF", {sram_a, regs_a}, 2'b10);
    cycle(16'h6000, 1, 0, 0, 8'h00);
    check("R5", "psen not sram", {sram_a, main_a}, {1'b0, 8'h01});
    cycle(16'h7F10, 0, 1, 0, 8'h00);
    check("R7", "window beats sram", {sram_a, regs_a}, 2'b01);
    cycle(16'h7F10, 1, 0, 0, 8'h00);
    check("R6", "psen not window", {regs_a, main_a}, {1'b0, 8'h01});
    bus_idle();
  endtask

  task automatic t_reserved();
    write_reg(8'hE0, 8'h01);
    write_reg(8'h10, 8'h55);
    write_reg(8'hE1, 8'hAA);
    cycle(16'h7FE0, 0, 1, 0, 8'h00);
    check("R9", "page kept after reserved writes", rdata_a, 8'h01);
    cycle(16'h7F10, 0, 1, 0, 8'h00);
    check("R9", "reserved read", rdata_a, 8'h00);
    check("R11", "oe on reserved read", oe_a, 1);
    cycle(16'h7FE0, 0, 0, 1, 8'h33);
    check("R11", "no oe on window write", oe_a, 0);
    bus_idle();
    @(posedge clk); #1;
    cycle(16'h1000, 1, 0, 0, 8'h00);
    check("R8", "new page used next cycle", main_a, exp_main(8'h33, 16'h1000));
    bus_idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_main_page0();
    t_paging();
    t_boot();
    t_sram_regs();
    t_reserved();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule